// File: doc/BRIEF.md
# Cache line flush controller

This block removes one cache line from a small two-level hierarchy on request. The hierarchy consists of a first-level data cache, a first-level instruction cache and a unified second-level cache. All three are direct-mapped tag/state/data arrays held inside the block. A flush request carries a byte address, and the block aligns that address down to its line. It looks the line up in all three arrays at once. Every dirty copy is sent to memory through a valid/ready write port. After that, every copy of the line is dropped.

Each request is checked the way a byte load would be. Two inputs can stop it. A global enable that is low rejects the flush as an illegal operation. A load-permission fault aborts it. A page marked execute-only does not stop it. Each completion reports an error code, and it also reports the page-attribute bits that a load would set.

Up to two flushes may be outstanding. Completions between flushes carry no ordering promise. A separate fence handshake gives ordering: the fence is acknowledged only once every flush accepted before it has finished, write-backs included. While the fence waits, new flushes are held off. A fill port lets the surrounding logic (here, the testbench) install lines.

Top module: `flush_ctrl`

## Requirements
- R1: A flush hits the line that holds any byte of it. Every memory write-back carries the line-aligned address: the low log2(LINE_BYTES) bits are zero.
- R2: After a successful flush, the line is absent from all three arrays. A repeat flush of any byte of it behaves as a miss. Fill selector codes: 0 = L1 data, 1 = L1 instruction, 2 = L2.
- R3: Only dirty copies produce memory writes, one write per dirty copy. Clean hits and misses produce no write.
- R4: When both the L2 and the L1 data copies are dirty, the L2 copy is written first and the L1 copy last. Each write carries the data of its own copy.
- R5: While `mem_valid` is high and `mem_ready` is low, the block keeps `mem_valid`, `mem_addr` and `mem_data` unchanged.
- R6: A request accepted while `feat_en` is 0 completes with `done_err` = 1. It makes no memory write and changes no array state.
- R7: A request accepted with `req_fault` = 1 completes with `done_err` = 2. It makes no memory write and changes no array state. `req_exec_only` alone never blocks a flush, and a successful flush gives `done_err` = 0.
- R8: A successful completion shows `done_acc` = 1 and `done_dirty` = 0. An errored completion shows `done_acc` = 0.
- R9: Count the accepting clock edge as edge 0. A miss or an errored flush shows `done_valid` for one cycle after edge 1. A clean hit shows it one cycle later, and each dirty copy adds one cycle when `mem_ready` is held high.
- R10: At most two flushes are outstanding. `req_ready` is low while two are outstanding, and high after reset.
- R11: `fence_ready` rises only when no flush is outstanding. `req_ready` is low while `fence_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Flush feature enable, sampled at acceptance |
| req_valid | input | 1 | Flush request valid |
| req_ready | output | 1 | Flush request can be accepted |
| req_addr | input | ADDR_W | Byte address to flush |
| req_id | input | ID_W | Tag echoed at completion |
| req_fault | input | 1 | Load-permission fault on the target |
| req_exec_only | input | 1 | Target page is execute-only |
| fence_valid | input | 1 | Fence request |
| fence_ready | output | 1 | Fence acknowledged (all earlier flushes done) |
| fill_valid | input | 1 | Install a line |
| fill_sel | input | 2 | Target array: 0 L1 data, 1 L1 instruction, 2 L2 |
| fill_addr | input | ADDR_W | Byte address of the installed line |
| fill_dirty | input | 1 | Installed line is dirty (ignored for the instruction array) |
| fill_data | input | DATA_W | Line payload |
| mem_valid | output | 1 | Write-back valid |
| mem_ready | input | 1 | Memory accepts the write-back |
| mem_addr | output | ADDR_W | Line-aligned write-back address |
| mem_data | output | DATA_W | Write-back payload |
| done_valid | output | 1 | One-cycle completion pulse |
| done_id | output | ID_W | Tag of the completed flush |
| done_err | output | 2 | 0 ok, 1 illegal operation, 2 permission fault |
| done_acc | output | 1 | Accessed bit reported |
| done_dirty | output | 1 | Dirty bit reported (always 0) |

## Verification
A fence can arrive while flushes are still draining. The critical cycle is the one in which the last earlier flush shows its completion pulse: the fence must not be acknowledged in that same cycle. The bench provokes this by stalling memory so that one flush sits in write-back and a second waits in the spare slot. It then raises the fence and releases memory. On the first cycle `fence_ready` is seen high, the bench requires that both completion pulses have already been counted and that no completion pulse is present in that cycle. It also requires that requests stay blocked for as long as the fence waits.

// File: rtl/flush_pkg.sv
package flush_pkg;

    localparam int unsigned LV_L1D = 0;
    localparam int unsigned LV_L1I = 1;
    localparam int unsigned LV_L2  = 2;
    localparam int unsigned N_LVL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_INVALIDATE,
        ST_DONE
    } flush_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ILLEGAL = 2'd1,
        ERR_FAULT   = 2'd2
    } flush_err_e;

    // Byte-load style permission check; a flush is exempt from execute-only.
    function automatic logic load_perm_fault(input logic fault, input logic exec_only,
                                             input logic is_flush);
        return fault || (exec_only && !is_flush);
    endfunction

    function automatic flush_err_e classify(input logic feat, input logic fault,
                                            input logic exec_only);
        if (!feat)
            return ERR_ILLEGAL;
        else if (load_perm_fault(fault, exec_only, 1'b1))
            return ERR_FAULT;
        else
            return ERR_NONE;
    endfunction

endpackage

// File: rtl/flush_tagarray.sv
module flush_tagarray #(
    parameter int unsigned SETS      = 16,
    parameter int unsigned LINE_W    = 26,
    parameter int unsigned DATA_W    = 32,
    parameter bit          HAS_DIRTY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_dirty,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    output logic              look_dirty,
    output logic [DATA_W-1:0] look_data,
    input  logic              inv_en
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = LINE_W - IDX_W;

    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   drt_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    logic [IDX_W-1:0] fill_idx, look_idx;
    logic [TAG_W-1:0] look_tag;

    assign fill_idx = fill_line[IDX_W-1:0];
    assign look_idx = look_line[IDX_W-1:0];
    assign look_tag = look_line[LINE_W-1:IDX_W];

    assign look_hit   = vld_q[look_idx] && (tag_q[look_idx] == look_tag);
    assign look_dirty = look_hit && drt_q[look_idx];
    assign look_data  = data_q[look_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
        end else begin
            if (inv_en && look_hit) begin
                vld_q[look_idx] <= 1'b0;
                drt_q[look_idx] <= 1'b0;
            end
            if (fill_en) begin
                vld_q[fill_idx] <= 1'b1;
                drt_q[fill_idx] <= fill_dirty && HAS_DIRTY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_line[LINE_W-1:IDX_W];
            data_q[fill_idx] <= fill_data;
        end
    end

endmodule

// File: rtl/flush_engine.sv
module flush_engine
    import flush_pkg::*;
#(
    parameter int unsigned LINE_W = 26,
    parameter int unsigned OFF_W  = 6,
    parameter int unsigned ID_W   = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LINE_W-1:0]       start_line,
    input  logic [ID_W-1:0]         start_id,
    input  flush_err_e              start_err,
    input  logic [N_LVL-1:0]        lvl_hit,
    input  logic [N_LVL-1:0]        lvl_dirty,
    input  logic [DATA_W-1:0]       l1d_data,
    input  logic [DATA_W-1:0]       l2_data,
    output logic                    can_take,
    output logic                    idle,
    output logic [LINE_W-1:0]       cur_line,
    output logic [N_LVL-1:0]        inv_en,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [LINE_W+OFF_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_data,
    output logic                    done_valid,
    output logic [ID_W-1:0]         done_id,
    output logic [1:0]              done_err,
    output logic                    done_acc,
    output logic                    done_dirty
);
    flush_state_e      state_q;
    logic [LINE_W-1:0] line_q;
    logic [ID_W-1:0]   id_q;
    flush_err_e        err_q;
    logic [1:0]        wb_q;   // bit0: L2 copy pending, bit1: L1 data copy pending

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            id_q    <= '0;
            err_q   <= ERR_NONE;
            wb_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        line_q  <= start_line;
                        id_q    <= start_id;
                        err_q   <= start_err;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (err_q != ERR_NONE || lvl_hit == '0) begin
                        state_q <= ST_DONE;
                    end else begin
                        wb_q    <= {lvl_dirty[LV_L1D], lvl_dirty[LV_L2]};
                        state_q <= (lvl_dirty[LV_L1D] || lvl_dirty[LV_L2])
                                   ? ST_WRITEBACK : ST_INVALIDATE;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_ready) begin
                        if (wb_q[0]) begin
                            wb_q[0] <= 1'b0;
                            state_q <= wb_q[1] ? ST_WRITEBACK : ST_INVALIDATE;
                        end else begin
                            wb_q[1] <= 1'b0;
                            state_q <= ST_INVALIDATE;
                        end
                    end
                end
                ST_INVALIDATE: state_q <= ST_DONE;
                ST_DONE: begin
                    if (start) begin
                        line_q  <= start_line;
                        id_q    <= start_id;
                        err_q   <= start_err;
                        state_q <= ST_LOOKUP;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign can_take   = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign idle       = (state_q == ST_IDLE);
    assign cur_line   = line_q;
    assign inv_en     = {N_LVL{state_q == ST_INVALIDATE}};
    assign mem_valid  = (state_q == ST_WRITEBACK);
    assign mem_addr   = {line_q, {OFF_W{1'b0}}};
    assign mem_data   = wb_q[0] ? l2_data : l1d_data;
    assign done_valid = (state_q == ST_DONE);
    assign done_id    = id_q;
    assign done_err   = err_q;
    assign done_acc   = done_valid && (err_q == ERR_NONE);
    assign done_dirty = 1'b0;

endmodule

// File: rtl/flush_ctrl.sv
module flush_ctrl
    import flush_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned L1_SETS    = 16,
    parameter int unsigned L2_SETS    = 64,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ID_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              feat_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_fault,
    input  logic              req_exec_only,
    input  logic              fence_valid,
    output logic              fence_ready,
    input  logic              fill_valid,
    input  logic [1:0]        fill_sel,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic [DATA_W-1:0] fill_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id,
    output logic [1:0]        done_err,
    output logic              done_acc,
    output logic              done_dirty
);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;

    // Spare request slot
    logic              pend_valid;
    logic [LINE_W-1:0] pend_line;
    logic [ID_W-1:0]   pend_id;
    flush_err_e        pend_err;

    logic              accept, start, eng_can_take, eng_idle;
    logic [LINE_W-1:0] req_line, start_line, cur_line;
    logic [ID_W-1:0]   start_id;
    flush_err_e        req_err, start_err;

    logic [N_LVL-1:0]  lvl_hit, lvl_dirty, inv_en;
    logic [DATA_W-1:0] lvl_data [N_LVL];

    assign req_line  = req_addr[ADDR_W-1:OFF_W];
    assign req_err   = classify(feat_en, req_fault, req_exec_only);
    assign req_ready = !fence_valid && !(pend_valid && !eng_idle);
    assign accept    = req_valid && req_ready;
    assign start     = eng_can_take && (pend_valid || accept);

    assign start_line = pend_valid ? pend_line : req_line;
    assign start_id   = pend_valid ? pend_id   : req_id;
    assign start_err  = pend_valid ? pend_err  : req_err;

    assign fence_ready = fence_valid && eng_idle && !pend_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_line  <= '0;
            pend_id    <= '0;
            pend_err   <= ERR_NONE;
        end else if (start && pend_valid) begin
            pend_valid <= accept;
            if (accept) begin
                pend_line <= req_line;
                pend_id   <= req_id;
                pend_err  <= req_err;
            end
        end else if (accept && !start) begin
            pend_valid <= 1'b1;
            pend_line  <= req_line;
            pend_id    <= req_id;
            pend_err   <= req_err;
        end
    end

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        localparam int unsigned SETS = (g == LV_L2) ? L2_SETS : L1_SETS;
        flush_tagarray #(
            .SETS      (SETS),
            .LINE_W    (LINE_W),
            .DATA_W    (DATA_W),
            .HAS_DIRTY (g != LV_L1I)
        ) u_arr (
            .clk        (clk),
            .rst        (rst),
            .fill_en    (fill_valid && (fill_sel == 2'(g))),
            .fill_line  (fill_addr[ADDR_W-1:OFF_W]),
            .fill_dirty (fill_dirty),
            .fill_data  (fill_data),
            .look_line  (cur_line),
            .look_hit   (lvl_hit[g]),
            .look_dirty (lvl_dirty[g]),
            .look_data  (lvl_data[g]),
            .inv_en     (inv_en[g])
        );
    end

    flush_engine #(
        .LINE_W (LINE_W),
        .OFF_W  (OFF_W),
        .ID_W   (ID_W),
        .DATA_W (DATA_W)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_line (start_line),
        .start_id   (start_id),
        .start_err  (start_err),
        .lvl_hit    (lvl_hit),
        .lvl_dirty  (lvl_dirty),
        .l1d_data   (lvl_data[LV_L1D]),
        .l2_data    (lvl_data[LV_L2]),
        .can_take   (eng_can_take),
        .idle       (eng_idle),
        .cur_line   (cur_line),
        .inv_en     (inv_en),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .done_valid (done_valid),
        .done_id    (done_id),
        .done_err   (done_err),
        .done_acc   (done_acc),
        .done_dirty (done_dirty)
    );

    logic unused_bits;
    assign unused_bits = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0],
                           lvl_data[LV_L1I], lvl_dirty[LV_L1I]};

endmodule

// File: rtl/flush_ctrl_chk.sv
module flush_ctrl_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 6,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              fence_valid,
    input logic              fence_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              done_valid,
    input logic [1:0]        done_err,
    input logic              done_acc
);
    logic [2:0] outst;

    always_ff @(posedge clk) begin
        if (rst)
            outst <= '0;
        else
            outst <= outst + 3'(req_valid && req_ready) - 3'(done_valid);
    end

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));                            // R1
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R5
    AST_ACC_ON_OK: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_err == 2'd0) |-> done_acc);                        // R8
    AST_NO_ACC_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_err != 2'd0) |-> !done_acc);                       // R8
    AST_MAX_TWO: assert property (@(posedge clk) disable iff (rst)
        outst <= 3'd2);                                                         // R10
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (outst == 3'd2) |-> !req_ready);                                        // R10
    AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        fence_ready |-> (outst == 3'd0));                                       // R11
    AST_FENCE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        fence_valid |-> !req_ready);                                            // R11

endmodule

bind flush_ctrl flush_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  ($clog2(LINE_BYTES)),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .fence_valid (fence_valid),
    .fence_ready (fence_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .done_valid  (done_valid),
    .done_err    (done_err),
    .done_acc    (done_acc)
);

// File: tb/tb_flush_ctrl.sv
module tb_flush_ctrl;
    localparam int AW = 16;
    localparam int LB = 16;
    localparam int DW = 16;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          feat_en = 1'b1, req_valid = 1'b0, req_fault = 1'b0, req_exec_only = 1'b0;
    logic          req_ready, fence_ready, mem_valid, done_valid, done_acc, done_dirty;
    logic [AW-1:0] req_addr = '0, fill_addr = '0, mem_addr;
    logic [IW-1:0] req_id = '0, done_id;
    logic          fence_valid = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0, mem_ready = 1'b1;
    logic [1:0]    fill_sel = '0, done_err;
    logic [DW-1:0] fill_data = '0, mem_data;

    flush_ctrl #(.ADDR_W(AW), .LINE_BYTES(LB), .L1_SETS(4), .L2_SETS(8),
                 .DATA_W(DW), .ID_W(IW)) dut (
        .clk(clk), .rst(rst), .feat_en(feat_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_id(req_id),
        .req_fault(req_fault), .req_exec_only(req_exec_only),
        .fence_valid(fence_valid), .fence_ready(fence_ready),
        .fill_valid(fill_valid), .fill_sel(fill_sel), .fill_addr(fill_addr),
        .fill_dirty(fill_dirty), .fill_data(fill_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .done_valid(done_valid), .done_id(done_id), .done_err(done_err),
        .done_acc(done_acc), .done_dirty(done_dirty));

    int n_run = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Observation of handshakes, away from the clock edge
    int wb_n = 0, d_n = 0, d_cyc = 0;
    int wb_a [16];
    int wb_d [16];
    int d_ids [8];
    int d_err = 0, d_acc = 0, d_drt = 0;
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            if (mem_valid && mem_ready) begin
                wb_a[wb_n % 16] = int'(mem_addr);
                wb_d[wb_n % 16] = int'(mem_data);
                wb_n++;
            end
            if (done_valid) begin
                d_ids[d_n % 8] = int'(done_id);
                d_err = int'(done_err);
                d_acc = int'(done_acc);
                d_drt = int'(done_dirty);
                d_cyc = cyc;
                d_n++;
            end
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic fill(input int sel, input int addr, input bit drt, input int data);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_sel   = sel[1:0];
        fill_addr  = addr[AW-1:0];
        fill_dirty = drt;
        fill_data  = data[DW-1:0];
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    int acc_cyc = 0;
    task automatic flush(input int addr, input int id, input bit fault, input bit xo);
        @(negedge clk);
        req_valid     = 1'b1;
        req_addr      = addr[AW-1:0];
        req_id        = id[IW-1:0];
        req_fault     = fault;
        req_exec_only = xo;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc       = cyc;
        req_valid     = 1'b0;
        req_fault     = 1'b0;
        req_exec_only = 1'b0;
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 300 && d_n < target; i++) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
        summary();
        $finish;
    end

    initial begin
        int w0, d0, nwb, hit, idx, base, off, l1d, l1i, l2, ha, hd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk("R10 req_ready after reset", int'(req_ready), 1);
        chk("R3 no write after reset", int'(mem_valid), 0);
        chk("R9 no completion after reset", int'(done_valid), 0);
        chk("R11 no fence ack without fence", int'(fence_ready), 0);

        // Sweep presence/dirtiness over all three arrays (R2 R3 R4 R8 R9)
        for (int k = 0; k < 18; k++) begin
            l1d  = k % 3;
            l1i  = (k / 3) % 2;
            l2   = k / 6;
            base = (k + 1) * LB;
            off  = (k * 5) % LB;
            if (l1d != 0) fill(0, base, l1d == 2, 'hD000 + k);
            if (l1i != 0) fill(1, base, 1'b1, 'h1000 + k);
            if (l2 != 0)  fill(2, base, l2 == 2, 'hB000 + k);
            w0 = wb_n;
            d0 = d_n;
            flush(base + off, k % 4, 1'b0, 1'b0);
            wait_done(d0 + 1);
            nwb = int'(l1d == 2) + int'(l2 == 2);
            hit = int'(l1d != 0 || l1i != 0 || l2 != 0);
            chk("R9 completion latency", d_cyc - acc_cyc, (hit != 0) ? 2 + nwb : 1);
            chk("R3 write count", wb_n - w0, nwb);
            idx = w0;
            if (l2 == 2) begin
                chk("R4 L2 copy first addr", wb_a[idx % 16], base);
                chk("R4 L2 copy data", wb_d[idx % 16], 'hB000 + k);
                idx++;
            end
            if (l1d == 2) begin
                chk("R4 L1 copy last addr", wb_a[idx % 16], base);
                chk("R4 L1 copy data", wb_d[idx % 16], 'hD000 + k);
            end
            chk("R7 ok code", d_err, 0);
            chk("R8 accessed bit", d_acc, 1);
            chk("R8 dirty bit", d_drt, 0);
            chk("R9 id echo", d_ids[d0 % 8], k % 4);
            w0 = wb_n;
            d0 = d_n;
            flush(base + LB - 1, 0, 1'b0, 1'b0);
            wait_done(d0 + 1);
            chk("R2 refLush is a miss", d_cyc - acc_cyc, 1);
            chk("R2 no write on refLush", wb_n - w0, 0);
        end

        // Byte-offset sweep (R1)
        for (int o = 0; o < LB; o++) begin
            base = (40 + o) * LB;
            fill(2, base + o, 1'b1, 'hA000 + o);
            w0 = wb_n;
            d0 = d_n;
            flush(base + ((o * 7 + 3) % LB), 1, 1'b0, 1'b0);
            wait_done(d0 + 1);
            chk("R1 aligned write addr", wb_a[w0 % 16], base);
            chk("R1 write data", wb_d[w0 % 16], 'hA000 + o);
        end

        // Feature disabled (R6)
        base = 'h300;
        fill(0, base, 1'b1, 'h1111);
        feat_en = 1'b0;
        w0 = wb_n;
        d0 = d_n;
        flush(base + 4, 2, 1'b0, 1'b0);
        wait_done(d0 + 1);
        chk("R6 illegal code", d_err, 1);
        chk("R6 no write", wb_n - w0, 0);
        chk("R9 error latency", d_cyc - acc_cyc, 1);
        chk("R8 no accessed on error", d_acc, 0);
        feat_en = 1'b1;
        flush(base, 2, 1'b0, 1'b0);
        wait_done(d0 + 2);
        chk("R6 state kept", wb_n - w0, 1);
        chk("R6 kept data", wb_d[w0 % 16], 'h1111);

        // Permission fault and execute-only (R7)
        base = 'h420;
        fill(2, base, 1'b1, 'h2222);
        w0 = wb_n;
        d0 = d_n;
        flush(base + 9, 3, 1'b1, 1'b0);
        wait_done(d0 + 1);
        chk("R7 fault code", d_err, 2);
        chk("R7 no write on fault", wb_n - w0, 0);
        flush(base, 3, 1'b0, 1'b1);
        wait_done(d0 + 2);
        chk("R7 exec-only not blocked", d_err, 0);
        chk("R7 state kept after fault", wb_n - w0, 1);
        chk("R7 kept data", wb_d[w0 % 16], 'h2222);

        // Stalled memory, two outstanding, fence in the completion cycle (R4 R5 R10 R11)
        fill(0, 'h500, 1'b1, 'h5151);
        fill(2, 'h500, 1'b1, 'h5252);
        fill(0, 'h610, 1'b1, 'h6161);
        mem_ready = 1'b0;
        w0 = wb_n;
        d0 = d_n;
        flush('h500 + 2, 1, 1'b0, 1'b0);
        flush('h610 + 15, 2, 1'b0, 1'b0);
        #2;
        chk("R10 ready low with two outstanding", int'(req_ready), 0);
        ha = int'(mem_addr);
        hd = int'(mem_data);
        chk("R4 L2 copy presented first", ha, 'h500);
        chk("R4 L2 data presented first", hd, 'h5252);
        repeat (3) @(negedge clk);
        #2;
        chk("R5 valid held", int'(mem_valid), 1);
        chk("R5 addr held", int'(mem_addr), ha);
        chk("R5 data held", int'(mem_data), hd);
        @(negedge clk);
        fence_valid = 1'b1;
        #2;
        chk("R11 fence waits", int'(fence_ready), 0);
        chk("R11 requests blocked by fence", int'(req_ready), 0);
        @(negedge clk);
        mem_ready = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #2;
            if (fence_ready) break;
        end
        chk("R11 fence ack after both done", d_n - d0, 2);
        chk("R11 no completion in ack cycle", int'(done_valid), 0);
        @(negedge clk);
        fence_valid = 1'b0;
        #2;
        chk("R10 ready restored", int'(req_ready), 1);
        chk("R3 three writes", wb_n - w0, 3);
        chk("R4 L1 copy after L2", wb_d[(w0 + 1) % 16], 'h5151);
        chk("R1 second line aligned", wb_a[(w0 + 2) % 16], 'h610);
        chk("R10 first id", d_ids[d0 % 8], 1);
        chk("R10 second id", d_ids[(d0 + 1) % 8], 2);

        summary();
        $finish;
    end

endmodule